// File: doc/BRIEF.md
# Counting Membership Filter with Memory-Held Counts

This block keeps one small counter for each slot of a hashed membership table. When an element enters a tracked set, its slot is incremented. When the element leaves, the slot is decremented. A probe answers either "definitely absent" (the slot is zero) or "possibly present" (the slot is nonzero). The counts live in a single-port synchronous memory. One shared up/down counter performs every adjustment, and a small sequencer steps each update through a read, a modify and a write, one cycle each.

A second single-port memory holds one flag per slot that is set exactly when the slot's count is zero. This flag is rewritten only when a count crosses zero in either direction. A probe reads only this flag and never the wide count, so a probe finishes in half the cycles of an update. Requests arrive through a valid/ready handshake with an operation code and a slot index. Probe answers come back with a response strobe.

After reset the block walks every slot and clears it, and it holds ready low until that walk is done. An increment on a full count or a decrement on a zero count leaves the count unchanged and raises a one-cycle error strobe.

Top module: `cbf_sram_ctrl`

## Requirements
- R1: After reset is released, req_ready_o stays low for exactly N_ENTRIES clock cycles while every slot is cleared, and it is high in the cycle after the last slot is written.
- R2: Once the clear has finished, a probe of any slot reports rsp_hit_o = 0.
- R3: Operation codes on req_op_i are: 2'b00 probe, 2'b01 increment, 2'b10 decrement, 2'b11 probe. A probe accepted in cycle t gives rsp_valid_o high for the single cycle t+1 and no other cycle. In that cycle req_ready_o is low and rsp_hit_o is 1 exactly when the slot's count is nonzero. req_ready_o is high again in cycle t+2.
- R4: An update accepted in cycle t holds req_ready_o low in cycles t+1, t+2 and t+3 (read, modify, write) and raises it in cycle t+4.
- R5: An increment adds one to the addressed count and a decrement subtracts one. A slot taken from zero to one probes as a hit, and a slot returned to zero probes as a miss.
- R6: An increment of a count already at 2^CNT_W-1 leaves the count unchanged and drives err_o high for exactly cycle t+3, where t is the acceptance cycle.
- R7: A decrement of a zero count leaves it at zero (no wrap) and drives err_o high for exactly cycle t+3.
- R8: An update of one slot does not change the probe result of any other slot.
- R9: err_o is high only in the cycle described in R6 and R7. rsp_valid_o and err_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with req_valid_i |
| req_op_i | input | 2 | Operation code (see R3) |
| req_idx_i | input | $clog2(N_ENTRIES) | Slot index |
| rsp_valid_o | output | 1 | Probe answer strobe |
| rsp_hit_o | output | 1 | 1 = slot nonzero (possibly present), 0 = definitely absent |
| err_o | output | 1 | One-cycle strobe for a suppressed overflow or underflow |

## Verification
The assertions check the handshake timing on every cycle. They check that ready stays low through the clear walk, that ready stays low for three cycles after each update, that a response follows each accepted probe one cycle later as a single strobe, that error strobes occur only three cycles after an accepted update, and that response and error never overlap. Only the bench scenarios can show the count contents. These include whether a hit follows the history of increments and decrements, saturation at the full value, the absence of wrap at zero, and the independence of neighbouring slots. The bench checks these against a reference model of the counts.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

  typedef enum logic [1:0] {
    OP_PROBE     = 2'b00,
    OP_INC       = 2'b01,
    OP_DEC       = 2'b10,
    OP_PROBE_ALT = 2'b11
  } cbf_op_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE,
    ST_PROBE
  } cbf_state_e;

  function automatic logic op_is_update(logic [1:0] op);
    return op[1] ^ op[0];
  endfunction

endpackage

// File: rtl/cbf_sp_ram.sv
module cbf_sp_ram #(
  parameter int unsigned WIDTH = 15,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  // one access per cycle; read data valid the cycle after
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_q       <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/cbf_updown_cnt.sv
module cbf_updown_cnt #(
  parameter int unsigned WIDTH = 15
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             dec_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             limit_o,
  output logic             was_zero_o,
  output logic             is_zero_o
);

  localparam logic [WIDTH-1:0] CntMax = {WIDTH{1'b1}};

  logic limit;

  always_comb begin
    limit = dec_i ? (cnt_i == '0) : (cnt_i == CntMax);
    if (limit)      cnt_o = cnt_i;
    else if (dec_i) cnt_o = cnt_i - 1'b1;
    else            cnt_o = cnt_i + 1'b1;
  end

  assign limit_o    = limit;
  assign was_zero_o = (cnt_i == '0);
  assign is_zero_o  = (cnt_o == '0);

endmodule

// File: rtl/cbf_clear_sweep.sv
module cbf_clear_sweep #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          active_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] LastAddr = AW'(DEPTH - 1);

  logic          active_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      addr_q   <= '0;
    end else if (active_q) begin
      if (addr_q == LastAddr) active_q <= 1'b0;
      else                    addr_q   <= addr_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q && (addr_q == LastAddr);
  assign addr_o   = addr_q;

endmodule

// File: rtl/cbf_sram_ctrl.sv
module cbf_sram_ctrl
  import cbf_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 1024,
  parameter int unsigned CNT_W     = 15,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [IDX_W-1:0] req_idx_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             err_o
);

  cbf_state_e       state_q;
  logic [1:0]       op_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] new_cnt_q;
  logic             cnt_we_q, z_we_q, z_val_q, err_q;

  logic             sweep_active, sweep_last;
  logic [IDX_W-1:0] sweep_addr;
  logic             accept, accept_probe;

  logic             cnt_en, cnt_we;
  logic [IDX_W-1:0] cnt_addr;
  logic [CNT_W-1:0] cnt_wdata, cnt_rdata;
  logic             z_en, z_we, z_wdata, z_rdata;
  logic [IDX_W-1:0] z_addr;

  logic [CNT_W-1:0] upd_cnt;
  logic             upd_limit, upd_was_zero, upd_is_zero;

  cbf_clear_sweep #(.DEPTH(N_ENTRIES)) i_sweep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_o (sweep_active),
    .last_o   (sweep_last),
    .addr_o   (sweep_addr)
  );

  assign req_ready_o  = (state_q == ST_IDLE);
  assign accept       = req_valid_i && req_ready_o;
  assign accept_probe = accept && !op_is_update(req_op_i);

  // count array: read in READ, written in WRITE unless suppressed
  always_comb begin
    cnt_en    = sweep_active || (state_q == ST_READ) || ((state_q == ST_WRITE) && cnt_we_q);
    cnt_we    = sweep_active || (state_q == ST_WRITE);
    cnt_addr  = sweep_active ? sweep_addr : idx_q;
    cnt_wdata = sweep_active ? '0 : new_cnt_q;
  end

  // zero-flag array: read straight from the request on probe accept
  always_comb begin
    z_en    = sweep_active || accept_probe || ((state_q == ST_WRITE) && z_we_q);
    z_we    = sweep_active || (state_q == ST_WRITE);
    z_addr  = sweep_active ? sweep_addr : (req_ready_o ? req_idx_i : idx_q);
    z_wdata = sweep_active || z_val_q;
  end

  cbf_sp_ram #(.WIDTH(CNT_W), .DEPTH(N_ENTRIES)) i_cnt_ram (
    .clk_i   (clk_i),
    .en_i    (cnt_en),
    .we_i    (cnt_we),
    .addr_i  (cnt_addr),
    .wdata_i (cnt_wdata),
    .rdata_o (cnt_rdata)
  );

  cbf_sp_ram #(.WIDTH(1), .DEPTH(N_ENTRIES)) i_zflag_ram (
    .clk_i   (clk_i),
    .en_i    (z_en),
    .we_i    (z_we),
    .addr_i  (z_addr),
    .wdata_i (z_wdata),
    .rdata_o (z_rdata)
  );

  cbf_updown_cnt #(.WIDTH(CNT_W)) i_updown (
    .cnt_i      (cnt_rdata),
    .dec_i      (op_q == OP_DEC),
    .cnt_o      (upd_cnt),
    .limit_o    (upd_limit),
    .was_zero_o (upd_was_zero),
    .is_zero_o  (upd_is_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_INIT;
      op_q      <= OP_PROBE;
      idx_q     <= '0;
      new_cnt_q <= '0;
      cnt_we_q  <= 1'b0;
      z_we_q    <= 1'b0;
      z_val_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= (state_q == ST_MODIFY) && upd_limit;
      unique case (state_q)
        ST_INIT: if (sweep_last) state_q <= ST_IDLE;
        ST_IDLE: begin
          if (req_valid_i) begin
            op_q    <= req_op_i;
            idx_q   <= req_idx_i;
            state_q <= op_is_update(req_op_i) ? ST_READ : ST_PROBE;
          end
        end
        ST_READ: state_q <= ST_MODIFY;
        ST_MODIFY: begin
          new_cnt_q <= upd_cnt;
          cnt_we_q  <= !upd_limit;
          // flag is touched only on a zero crossing
          z_we_q    <= !upd_limit && (upd_was_zero != upd_is_zero);
          z_val_q   <= upd_is_zero;
          state_q   <= ST_WRITE;
        end
        ST_WRITE: state_q <= ST_IDLE;
        ST_PROBE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = (state_q == ST_PROBE);
  assign rsp_hit_o   = rsp_valid_o && !z_rdata;
  assign err_o       = err_q;

endmodule

// File: rtl/cbf_sram_ctrl_chk.sv
module cbf_sram_ctrl_chk #(
  parameter int unsigned N_ENTRIES = 1024,
  localparam int unsigned CW       = $clog2(N_ENTRIES + 1)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [1:0] req_op_i,
  input logic       rsp_valid_o,
  input logic       err_o
);

  localparam logic [CW-1:0] SweepLen = CW'(N_ENTRIES);

  logic [CW-1:0] cyc_q;
  logic          sweep_done;
  logic          acc_upd, acc_prb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cyc_q <= '0;
    else if (cyc_q != SweepLen) cyc_q <= cyc_q + 1'b1;
  end

  assign sweep_done = (cyc_q == SweepLen);
  assign acc_upd    = req_valid_i && req_ready_o && (req_op_i[1] ^ req_op_i[0]);
  assign acc_prb    = req_valid_i && req_ready_o && !(req_op_i[1] ^ req_op_i[0]);

  // R1
  a_r1_no_ready_in_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> sweep_done);
  a_r1_ready_after_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sweep_done) |-> req_ready_o);

  // R3
  a_r3_probe_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_prb |=> rsp_valid_o && !req_ready_o ##1 !rsp_valid_o && req_ready_o);
  a_r3_rsp_after_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(acc_prb));

  // R4
  a_r4_update_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_upd |=> !req_ready_o ##1 !req_ready_o ##1 !req_ready_o ##1 req_ready_o);

  // R6 R7
  a_r6_err_after_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(acc_upd, 3));
  a_r7_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  // R9
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && err_o));

endmodule

bind cbf_sram_ctrl cbf_sram_ctrl_chk #(.N_ENTRIES(N_ENTRIES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_op_i    (req_op_i),
  .rsp_valid_o (rsp_valid_o),
  .err_o       (err_o)
);

// File: tb/test_cbf_sram_ctrl.sv
module test_cbf_sram_ctrl;

  localparam int unsigned N     = 16;
  localparam int unsigned W     = 3;
  localparam int unsigned IW    = $clog2(N);
  localparam int          MAXC  = (1 << W) - 1;

  localparam logic [1:0] OP_PRB = 2'b00;
  localparam logic [1:0] OP_INC = 2'b01;
  localparam logic [1:0] OP_DEC = 2'b10;
  localparam logic [1:0] OP_PRB2 = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [IW-1:0] idx = '0;
  logic          ready, rsp_valid, rsp_hit, err;

  always #2 clk = ~clk;

  cbf_sram_ctrl #(.N_ENTRIES(N), .CNT_W(W)) i_cbf_sram_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (valid),
    .req_ready_o (ready),
    .req_op_i    (op),
    .req_idx_i   (idx),
    .rsp_valid_o (rsp_valid),
    .rsp_hit_o   (rsp_hit),
    .err_o       (err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int model [N];

  // scoreboard: kind 0 = probe answer, kind 1 = error strobe
  int    exp_kind [$];
  int    exp_val  [$];
  string exp_tag  [$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid && err) check(1'b0, "R9 rsp/err overlap", 1, 0);
      if (rsp_valid) begin
        if (exp_kind.size() == 0 || exp_kind[0] != 0) begin
          check(1'b0, "R3 unexpected response", 1, 0);
        end else begin
          check(rsp_hit == exp_val[0][0], exp_tag[0], int'(rsp_hit), exp_val[0]);
          void'(exp_kind.pop_front()); void'(exp_val.pop_front()); void'(exp_tag.pop_front());
        end
      end
      if (err) begin
        if (exp_kind.size() == 0 || exp_kind[0] != 1) begin
          check(1'b0, "R9 unexpected err_o", 1, 0);
        end else begin
          check(1'b1, exp_tag[0], 1, 1);
          void'(exp_kind.pop_front()); void'(exp_val.pop_front()); void'(exp_tag.pop_front());
        end
      end
    end
  end

  // returns 1 when the update is expected to be suppressed
  function automatic bit push_expect(input logic [1:0] o, input int i, input string tag);
    bit sup = 1'b0;
    if (o == OP_INC) begin
      if (model[i] == MAXC) sup = 1'b1; else model[i]++;
    end else if (o == OP_DEC) begin
      if (model[i] == 0) sup = 1'b1; else model[i]--;
    end else begin
      exp_kind.push_back(0); exp_val.push_back(model[i] != 0 ? 1 : 0); exp_tag.push_back(tag);
    end
    if (sup) begin
      exp_kind.push_back(1); exp_val.push_back(1); exp_tag.push_back(tag);
    end
    return sup;
  endfunction

  task automatic send(input logic [1:0] o, input int i, input string tag);
    @(negedge clk);
    while (!ready) @(negedge clk);
    void'(push_expect(o, i, tag));
    valid = 1'b1; op = o; idx = IW'(i);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic timed_probe(input logic [1:0] o, input int i);
    @(negedge clk);
    while (!ready) @(negedge clk);
    void'(push_expect(o, i, "R3 timed probe hit"));
    valid = 1'b1; op = o; idx = IW'(i);
    @(negedge clk);
    valid = 1'b0;
    check(rsp_valid == 1'b1, "R3 rsp_valid at t+1", int'(rsp_valid), 1);
    check(ready == 1'b0, "R3 ready low at t+1", int'(ready), 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R3 rsp_valid at t+2", int'(rsp_valid), 0);
    check(ready == 1'b1, "R3 ready at t+2", int'(ready), 1);
  endtask

  task automatic timed_update(input logic [1:0] o, input int i, input string tag);
    bit sup;
    @(negedge clk);
    while (!ready) @(negedge clk);
    sup = push_expect(o, i, tag);
    valid = 1'b1; op = o; idx = IW'(i);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      valid = 1'b0;
      check(ready == (k == 4), "R4 ready pattern", int'(ready), int'(k == 4));
      check(err == (sup && k == 3), {tag, " err timing"}, int'(err), int'(sup && k == 3));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    check(ready == 1'b0 && rsp_valid == 1'b0 && err == 1'b0, "R1 reset state",
          int'({ready, rsp_valid, err}), 0);
    rst_n = 1'b1;
    for (int k = 1; k <= N; k++) begin
      @(negedge clk);
      check(ready == (k == N), "R1 clear sweep ready", int'(ready), int'(k == N));
    end

    // R2: every slot cleared
    for (int i = 0; i < N; i++) send(OP_PRB, i, "R2 probe after clear");

    // R4 R5 R8
    timed_update(OP_INC, 3, "R5 inc");
    timed_probe(OP_PRB, 3);
    send(OP_PRB, 4, "R8 neighbour untouched");
    send(OP_PRB, 2, "R8 neighbour untouched");
    timed_update(OP_DEC, 3, "R5 dec");
    send(OP_PRB, 3, "R5 back to zero");

    // R6: saturate slot 5
    for (int k = 0; k < MAXC; k++) send(OP_INC, 5, "R6 inc below max");
    timed_update(OP_INC, 5, "R6 inc at max");
    for (int k = 0; k < MAXC - 1; k++) send(OP_DEC, 5, "R6 dec from max");
    send(OP_PRB, 5, "R6 count one after max-1 decs");
    send(OP_DEC, 5, "R6 last dec");
    send(OP_PRB, 5, "R6 zero after max decs");

    // R7: no wrap below zero
    timed_update(OP_DEC, 5, "R7 dec at zero");
    send(OP_PRB, 5, "R7 still zero");
    send(OP_INC, 5, "R7 inc after underflow");
    send(OP_PRB, 5, "R7 one after underflow");
    send(OP_DEC, 5, "R7 dec to zero");
    send(OP_PRB, 5, "R7 zero again");

    // mixed slots, alternate probe code
    send(OP_INC, 0, "R5 inc slot0");
    send(OP_INC, 0, "R5 inc slot0");
    send(OP_INC, N - 1, "R5 inc last slot");
    send(OP_DEC, 0, "R5 dec slot0");
    send(OP_PRB, 0, "R5 slot0 one");
    send(OP_PRB2, N - 1, "R3 alt probe code");
    send(OP_PRB, 1, "R8 slot1 untouched");
    send(OP_DEC, 0, "R5 dec slot0");
    send(OP_PRB2, 0, "R3 alt probe slot0 zero");
    timed_probe(OP_PRB2, N - 1);

    repeat (6) @(negedge clk);
    check(exp_kind.size() == 0, "R9 all expected strobes seen", exp_kind.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule